// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked on-chip requester and an external asynchronous static RAM of 131,072 sixteen-bit words. The requester raises a request carrying a 17-bit word address, a 16-bit write word, a two-bit lane mask and a read/write flag. It holds the request until a one-cycle acknowledge returns. Reads also return a data word and a valid flag in that acknowledge cycle.

Toward the memory the block drives the address, the active-low chip select, read enable, write strobe and two lane strobes, plus a data word and its drive enable. The asynchronous timing figures are held as nanosecond parameters. The block turns them into cycle counts by dividing by the clock period and rounding up. After a read it holds off any write until the memory has had time to float its outputs, so the two sides never drive the data pins together.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, with no request pending, every memory control output is high (inactive), `mem_dq_oe` is low, and `ack` and `rd_valid` are low.
- R2: A request whose lane mask is 00 is acknowledged in the cycle after it is accepted. Chip select stays high throughout, memory contents are unchanged and `rd_valid` stays low.
- R3: A write asserts chip select and the lane strobes selected by the mask: mask bit 0 drives `mem_lb_n` and data bits 7:0, and mask bit 1 drives `mem_ub_n` and bits 15:8. It pulls the write strobe low for WP_CYC = ceil(max(T_WP, T_WC - 2*CLK) / CLK) cycles (6 at the defaults). Only the selected lanes of the memory word change.
- R4: `mem_dq_oe` is high only while `mem_we_n` is low. It is low in the cycle in which `mem_we_n` returns high.
- R5: During a write, chip select and the lane strobes are low for one cycle before and one cycle after the write-strobe pulse. Address, strobes and write data do not change while the write strobe is low.
- R6: A read holds chip select and read enable low, with the write strobe high, for RD_CYC = ceil(T_AA / CLK) cycles (7 at the defaults). The data is sampled at the end of the last cycle. Lanes outside the mask read as zero, and `rd_valid` is high together with `ack`.
- R7: After a read ends, the data drive enable stays low for at least TURN_CYC = max(1, ceil(T_OHZ / CLK)) cycles (3 at the defaults). A write that follows a read is delayed until this window has passed.
- R8: The read enable and the write strobe are never low in the same cycle.
- R9: Counting clock edges from the accepting edge to the first cycle with `ack` high, a write takes WP_CYC+3 cycles, a read RD_CYC+1 and a zero-mask request 1. A write started while the turnaround window is running adds the remaining cycles of that window.
- R10: `ack` is high for exactly one cycle per request. A request is accepted only from the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write word |
| ack | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Read data valid, with ack |
| rd_data | output | 16 | Read word, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned by memory |

## Verification
The bench's memory model supplies garbage until the access time has elapsed and a distinct filler on unselected lanes. A controller that samples a cycle early, or that fails to zero unused lanes, therefore returns wrong words. Writes with single-lane masks followed by full reads expose a swapped or ignored lane strobe. A zero-mask write followed by a readback shows whether such a write leaks into memory. Read-then-write pairs test the turnaround window: the model counts any overlap of controller drive with its own float time, so a missing or short turnaround shows up as a contention violation and a shortened latency. Exact latencies and the model's pulse-width check catch a write pulse or access window that is off by one.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_TURN,
      ST_SETUP,
      ST_WPULSE,
      ST_WEND,
      ST_RACC,
      ST_DONE
   } seq_state_t;

   // integer division rounded toward +infinity
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
   import sram_lane_pkg::*;
#(
   parameter int RD_CYC   = 7,
   parameter int WP_CYC   = 6,
   parameter int TURN_CYC = 3,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req,
   input  logic             req_we,
   input  logic             req_any_lane,
   input  logic             acc_zero,
   input  logic             turn_zero,
   output seq_state_t       state,
   output logic             accept,
   output logic             capture,
   output logic             acc_load,
   output logic [CNT_W-1:0] acc_val,
   output logic             turn_load,
   output logic [CNT_W-1:0] turn_val
);

   localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
   localparam logic [CNT_W-1:0] TURN_LD = CNT_W'(TURN_CYC);

   seq_state_t state_q, state_d;

   always_comb begin
      state_d   = state_q;
      accept    = 1'b0;
      capture   = 1'b0;
      acc_load  = 1'b0;
      acc_val   = '0;
      turn_load = 1'b0;
      turn_val  = TURN_LD;
      unique case (state_q)
         ST_IDLE: begin
            if (req) begin
               accept = 1'b1;
               if (!req_any_lane) begin
                  state_d = ST_DONE;
               end else if (req_we) begin
                  state_d = turn_zero ? ST_SETUP : ST_TURN;
               end else begin
                  state_d  = ST_RACC;
                  acc_load = 1'b1;
                  acc_val  = RD_LAST;
               end
            end
         end
         ST_TURN: begin
            if (turn_zero) state_d = ST_SETUP;
         end
         ST_SETUP: begin
            state_d  = ST_WPULSE;
            acc_load = 1'b1;
            acc_val  = WP_LAST;
         end
         ST_WPULSE: begin
            if (acc_zero) state_d = ST_WEND;
         end
         ST_WEND: begin
            state_d = ST_DONE;
         end
         ST_RACC: begin
            if (acc_zero) begin
               state_d   = ST_DONE;
               capture   = 1'b1;
               turn_load = 1'b1;
            end
         end
         ST_DONE: begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

endmodule

// File: rtl/sram_io_path.sv
module sram_io_path #(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 16,
   parameter int LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              req_we,
   input  logic [LANES-1:0]  req_be,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] dq_i,
   output logic              we_q,
   output logic [LANES-1:0]  be_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   localparam int LANE_W = DATA_W / LANES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q    <= 1'b0;
         be_q    <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         we_q    <= req_we;
         be_q    <= req_be;
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   // one capture register per lane; unselected lanes load zero
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q[g*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rdata_q[g*LANE_W +: LANE_W] <= be_q[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
         end
      end
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W      = 17,
   parameter int DATA_W      = 16,
   parameter int CLK_NS      = 10,
   parameter int T_AA_NS     = 70,
   parameter int T_WC_NS     = 70,
   parameter int T_WP_NS     = 60,
   parameter int T_DS_NS     = 30,
   parameter int T_OHZ_NS    = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              req_we,
   input  logic [1:0]        req_be,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ack,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_ub_n,
   output logic              mem_lb_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);

   localparam int LANES    = 2;
   localparam int RD_CYC   = max2(1, ceil_div(T_AA_NS, CLK_NS));
   localparam int WP_CYC   = max2(1, max2(ceil_div(T_WP_NS, CLK_NS),
                                          ceil_div(T_WC_NS, CLK_NS) - 2));
   localparam int TURN_CYC = max2(1, ceil_div(T_OHZ_NS, CLK_NS));
   localparam int CNT_MAX  = max2(RD_CYC, max2(WP_CYC, TURN_CYC));
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   // elaboration-time parameter checks
   if (DATA_W != 16) begin : g_bad_width
      $error("sram_lane_ctrl: DATA_W must be 16 (two byte lanes)");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_lane_ctrl: ADDR_W must be positive");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_lane_ctrl: CLK_NS must be positive");
   end
   if (T_DS_NS > T_WP_NS) begin : g_bad_setup
      $error("sram_lane_ctrl: data setup must fit inside the write pulse");
   end

   seq_state_t        state;
   logic              accept, capture;
   logic              acc_load, acc_zero;
   logic              turn_load, turn_zero;
   logic [CNT_W-1:0]  acc_val, turn_val;
   logic              we_q;
   logic [LANES-1:0]  be_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              cycle_live;

   sram_seq_fsm #(
      .RD_CYC   (RD_CYC),
      .WP_CYC   (WP_CYC),
      .TURN_CYC (TURN_CYC),
      .CNT_W    (CNT_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .req_we       (req_we),
      .req_any_lane (|req_be),
      .acc_zero     (acc_zero),
      .turn_zero    (turn_zero),
      .state        (state),
      .accept       (accept),
      .capture      (capture),
      .acc_load     (acc_load),
      .acc_val      (acc_val),
      .turn_load    (turn_load),
      .turn_val     (turn_val)
   );

   sram_cyc_timer #(.CNT_W(CNT_W)) u_acc_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_load),
      .load_val (acc_val),
      .zero     (acc_zero)
   );

   sram_cyc_timer #(.CNT_W(CNT_W)) u_turn_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (turn_load),
      .load_val (turn_val),
      .zero     (turn_zero)
   );

   sram_io_path #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .LANES  (LANES)
   ) u_io (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_we    (req_we),
      .req_be    (req_be),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_i      (mem_dq_i),
      .we_q      (we_q),
      .be_q      (be_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .rdata_q   (rdata_q)
   );

   always_comb begin
      cycle_live = (state == ST_SETUP) || (state == ST_WPULSE) ||
                   (state == ST_WEND)  || (state == ST_RACC);
      mem_ce_n   = !cycle_live;
      mem_we_n   = (state != ST_WPULSE);
      mem_oe_n   = (state != ST_RACC);
      mem_lb_n   = !(cycle_live && be_q[0]);
      mem_ub_n   = !(cycle_live && be_q[1]);
      mem_dq_oe  = (state == ST_WPULSE);
      mem_dq_o   = wdata_q;
      mem_addr   = addr_q;
      ack        = (state == ST_DONE);
      rd_valid   = (state == ST_DONE) && !we_q && (|be_q);
      rd_data    = rdata_q;
   end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
   parameter int ADDR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ce_n,
   input logic              mem_oe_n,
   input logic              mem_we_n,
   input logic              mem_ub_n,
   input logic              mem_lb_n,
   input logic              mem_dq_oe
);

   p_drive_we_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> !mem_we_n);

   p_release_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_oe);

   p_oe_we_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

   p_write_needs_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (!mem_ce_n && !(mem_ub_n && mem_lb_n)));

   p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

   p_strobe_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_ub_n) && $stable(mem_lb_n)));

   p_ce_before_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $past(!mem_ce_n));

   p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   p_rdvalid_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ack);

   p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |-> !mem_dq_oe);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .rd_valid  (rd_valid),
   .mem_addr  (mem_addr),
   .mem_ce_n  (mem_ce_n),
   .mem_oe_n  (mem_oe_n),
   .mem_we_n  (mem_we_n),
   .mem_ub_n  (mem_ub_n),
   .mem_lb_n  (mem_lb_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb;

   localparam int CLK_PERIOD = 10;
   localparam int RD_CYC     = 7;   // ceil(70/10)
   localparam int WP_CYC     = 6;   // ceil(60/10), write cycle 70 fits in 6+2
   localparam int TURN_CYC   = 3;   // ceil(25/10)
   localparam int FLOAT_CYC  = 3;   // model keeps driving this long after read ends
   localparam int NVEC       = 12;

   // {we, be[1:0], addr[16:0], wdata[15:0], expected read[15:0]}
   localparam logic [51:0] VEC [NVEC] = '{
      {1'b1, 2'b11, 17'h00010, 16'h1234, 16'h0000},
      {1'b0, 2'b11, 17'h00010, 16'h0000, 16'h1234},
      {1'b1, 2'b01, 17'h00010, 16'hABCD, 16'h0000},
      {1'b0, 2'b11, 17'h00010, 16'h0000, 16'h12CD},
      {1'b1, 2'b10, 17'h1FF20, 16'h5566, 16'h0000},
      {1'b0, 2'b10, 17'h1FF20, 16'h0000, 16'h5500},
      {1'b0, 2'b01, 17'h00010, 16'h0000, 16'h00CD},
      {1'b1, 2'b00, 17'h00010, 16'hFFFF, 16'h0000},
      {1'b0, 2'b11, 17'h00010, 16'h0000, 16'h12CD},
      {1'b0, 2'b00, 17'h00010, 16'h0000, 16'h0000},
      {1'b1, 2'b11, 17'h0AA33, 16'hBEEF, 16'h0000},
      {1'b0, 2'b11, 17'h0AA33, 16'h0000, 16'hBEEF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        req_we = 1'b0;
   logic [1:0]  req_be = 2'b00;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        ack, rd_valid;
   logic [15:0] rd_data;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
   logic [15:0] mem_dq_o;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_i;

   int tests = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_lane_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .req_we    (req_we),
      .req_be    (req_be),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .ack       (ack),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data),
      .mem_addr  (mem_addr),
      .mem_ce_n  (mem_ce_n),
      .mem_oe_n  (mem_oe_n),
      .mem_we_n  (mem_we_n),
      .mem_ub_n  (mem_ub_n),
      .mem_lb_n  (mem_lb_n),
      .mem_dq_o  (mem_dq_o),
      .mem_dq_oe (mem_dq_oe),
      .mem_dq_i  (mem_dq_i)
   );

   // ---------------- behavioural memory model (low 8 address bits) -------
   logic [15:0] mem [256];
   logic        rd_en, wr_act, prev_wr;
   int          rcnt, wcnt, hold;
   logic [16:0] w_addr;
   logic [15:0] w_data;
   logic        w_lb, w_ub;
   int          viol_r3 = 0, viol_r4 = 0, viol_r5 = 0, viol_r7 = 0, viol_r8 = 0;

   assign rd_en  = !mem_ce_n && !mem_oe_n && mem_we_n && !(mem_lb_n && mem_ub_n);
   assign wr_act = !mem_ce_n && !mem_we_n && !(mem_lb_n && mem_ub_n);

   always_comb begin
      if (rd_en && (rcnt + 1) * CLK_PERIOD >= 70) begin
         mem_dq_i[7:0]  = !mem_lb_n ? mem[mem_addr[7:0]][7:0]  : 8'h5A;
         mem_dq_i[15:8] = !mem_ub_n ? mem[mem_addr[7:0]][15:8] : 8'h5A;
      end else if (rd_en) begin
         mem_dq_i = 16'hA5A5;
      end else begin
         mem_dq_i = 16'h5A5A;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         rcnt <= 0; wcnt <= 0; hold <= 0; prev_wr <= 1'b0;
      end else begin
         rcnt <= rd_en ? rcnt + 1 : 0;
         hold <= rd_en ? FLOAT_CYC : ((hold > 0) ? hold - 1 : 0);
         if (mem_dq_oe && (rd_en || hold > 0)) viol_r7 <= viol_r7 + 1;
         if (mem_dq_oe && mem_we_n)            viol_r4 <= viol_r4 + 1;
         if (!mem_oe_n && !mem_we_n)           viol_r8 <= viol_r8 + 1;
         prev_wr <= wr_act;
         if (wr_act) begin
            if (!mem_dq_oe) viol_r4 <= viol_r4 + 1;
            if (prev_wr && (mem_addr != w_addr || mem_dq_o != w_data ||
                            (!mem_lb_n) != w_lb || (!mem_ub_n) != w_ub))
               viol_r5 <= viol_r5 + 1;
            w_addr <= mem_addr; w_data <= mem_dq_o;
            w_lb   <= !mem_lb_n; w_ub <= !mem_ub_n;
            wcnt   <= wcnt + 1;
         end else if (prev_wr) begin
            if (wcnt * CLK_PERIOD < 60) viol_r3 <= viol_r3 + 1;
            if (mem_ce_n) viol_r5 <= viol_r5 + 1;   // no hold cycle after pulse
            if (w_lb) mem[w_addr[7:0]][7:0]  <= w_data[7:0];
            if (w_ub) mem[w_addr[7:0]][15:8] <= w_data[15:8];
            wcnt <= 0;
         end
      end
   end

   // ---------------- checking helpers -------------------------------------
   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   int          op_lat;
   logic [15:0] op_rdata;
   logic        op_rv;
   logic        op_ce_seen;
   logic        op_ack_after;

   task automatic run_op(input logic we, input logic [1:0] be,
                         input logic [16:0] a, input logic [15:0] d);
      @(negedge clk);
      req = 1'b1; req_we = we; req_be = be; req_addr = a; req_wdata = d;
      op_lat = 0; op_ce_seen = 1'b0;
      do begin
         @(posedge clk); #1;
         op_lat++;
         if (!mem_ce_n) op_ce_seen = 1'b1;
      end while (!ack && op_lat < 100);
      op_rdata = rd_data;
      op_rv    = rd_valid;
      @(negedge clk);
      req = 1'b0;
      @(posedge clk); #1;
      op_ack_after = ack;
   endtask

   // ---------------- watchdog ---------------------------------------------
   initial begin
      repeat (100000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   // ---------------- main sequence ----------------------------------------
   initial begin
      logic prev_read;
      int   exp_lat;
      for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

      // R1: reset state while held and just after release
      repeat (3) @(posedge clk);
      #1;
      check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n,
            "R1 strobes idle in reset", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'h1F);
      check(!mem_dq_oe && !ack && !rd_valid, "R1 outputs low in reset",
            {mem_dq_oe, ack, rd_valid}, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && !ack,
            "R1 idle after reset", {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, ack}, 5'h1C);

      // table walk
      prev_read = 1'b0;
      for (int v = 0; v < NVEC; v++) begin
         logic        vwe;
         logic [1:0]  vbe;
         logic [16:0] va;
         logic [15:0] vd, vexp;
         {vwe, vbe, va, vd, vexp} = VEC[v];
         run_op(vwe, vbe, va, vd);

         if (vbe == 2'b00) begin
            exp_lat = 1;
            check(op_lat == exp_lat, "R9 zero-mask latency", op_lat, exp_lat);
            check(!op_ce_seen, "R2 no chip select on zero mask", op_ce_seen, 0);
            check(!op_rv, "R2 no read valid on zero mask", op_rv, 0);
         end else if (vwe) begin
            exp_lat = prev_read ? WP_CYC + 3 + TURN_CYC - 1 : WP_CYC + 3;
            check(op_lat == exp_lat, prev_read ? "R7 write after read latency" : "R9 write latency",
                  op_lat, exp_lat);
         end else begin
            exp_lat = RD_CYC + 1;
            check(op_lat == exp_lat, "R9 read latency", op_lat, exp_lat);
            check(op_rv, "R6 read valid with ack", op_rv, 1);
            check(op_rdata == vexp, "R3 R6 read data and lane mapping", op_rdata, vexp);
         end
         check(!op_ack_after, "R10 ack single cycle", op_ack_after, 0);
         prev_read = !vwe && (vbe != 2'b00);
      end

      // directed: request held beyond ack is not taken until idle (R10)
      @(negedge clk);
      req = 1'b1; req_we = 1'b0; req_be = 2'b11; req_addr = 17'h00010;
      begin
         int n;
         int acks;
         n = 0; acks = 0;
         repeat (2 * (RD_CYC + 2)) begin
            @(posedge clk); #1;
            n++;
            if (ack) acks++;
         end
         req = 1'b0;
         check(acks == 2, "R10 held request served back to back", acks, 2);
      end
      repeat (RD_CYC + 4) @(posedge clk);
      #1;
      check(mem_ce_n && !ack, "R10 idle after request drop", {mem_ce_n, ack}, 2'b10);

      // model-reported protocol checks
      check(viol_r3 == 0, "R3 write pulse width", viol_r3, 0);
      check(viol_r4 == 0, "R4 drive only while write strobe low", viol_r4, 0);
      check(viol_r5 == 0, "R5 stable address, data and strobes", viol_r5, 0);
      check(viol_r7 == 0, "R7 bus contention after read", viol_r7, 0);
      check(viol_r8 == 0, "R8 read and write enables overlap", viol_r8, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule